// File: doc/BRIEF.md
# Keyed-Write Watchdog Timer

This block is a watchdog timer that sits on a simple register bus and counts a slow periodic tick, nominally 32 kHz, presented as a one-cycle enable on the system clock. Software sets a timeout length in coarse units of 512 ticks, enables counting, and reloads the counter often enough to keep it from running out. When the counter does run out, the block raises a reset pulse of fixed length on its output pin. The pin polarity can be chosen. In two-stage mode, the first run-out only flags an interrupt, and a reset follows only if the next run-out also goes unserviced.

Every control write must carry a magic value that belongs to the register it targets; any other write is dropped without a trace. A software-reset register fires the reset pulse at once, whatever the counter holds. A status register records whether the last reset was caused by a run-out or by software.

Top module: `keyed_wdt`

## Requirements
- R1: After reset the timer is disabled, length, counter, status and all mode fields are zero, `wdt_irq` is low and `wdt_rst_out` is high (inactive, active-low polarity).
- R2: A write to offset 0x00 changes the mode fields only when bits [31:24] equal 0x22. The fields are: bit 0 enable, bit 1 polarity, bit 2 reset-pin enable, bit 3 interrupt enable, bit 6 two-stage mode. A read returns these fields with every other bit, including the key, at zero.
- R3: A write to offset 0x04 is accepted only when bits [4:0] equal 0x08. The timeout unit count is bits [15:5]. An accepted write stores the count and reloads the counter to count×512. A read returns the count at bits [15:5] with zeros elsewhere.
- R4: Writing exactly 0x0000_1971 to offset 0x08 reloads the counter to length×512 and clears a pending interrupt. Any other value has no effect.
- R5: While enabled, the counter drops by one on each tick. While disabled it holds its value. Offset 0x10 reads the live counter value.
- R6: A tick while enabled with the counter at zero is a run-out, and the counter reloads to length×512. Outside two-stage mode, a run-out is a reset event: status bit 31 sets, and if bit 2 of mode is set, the reset pin is driven active for 16 clock cycles starting the cycle after the event. A new trigger restarts the 16.
- R7: The reset pin is active low when the polarity bit is 0 and active high when it is 1, and sits at the opposite level otherwise.
- R8: In two-stage mode, a run-out with no interrupt pending sets it pending, and `wdt_irq` is high while it is pending and bit 3 is set. A run-out with an interrupt pending is a reset event and clears the pending flag.
- R9: Writing exactly 0x0000_1209 to offset 0x14 starts a 16-cycle reset pulse, whatever the counter and bit 2 hold, and sets status bit 30. Any other value has no effect.
- R10: Status (offset 0x0C) reads bit 31 for a run-out reset and bit 30 for a software reset. An accepted mode write clears both. An event in the same cycle as that clear leaves its bit set.
- R11: Reads of offsets 0x08, 0x14 and every unmapped offset return zero. Writes to status, counter and unmapped offsets change nothing.
- R12: An accepted restart or length write in the same cycle as a tick that would cause a run-out suppresses the run-out; the reload wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick | input | 1 | One-cycle count enable from the slow time base |
| bus_addr | input | ADDR_W | Byte offset of the register access |
| bus_we | input | 1 | Write strobe for the current cycle |
| bus_wdata | input | 32 | Write data including the register key |
| bus_rdata | output | 32 | Read data for `bus_addr`, same cycle |
| wdt_rst_out | output | 1 | Reset pulse pin, polarity set by mode bit 1 |
| wdt_irq | output | 1 | Two-stage warning interrupt |

## Verification
The sharpest collision is a software reload arriving on the very tick that finds the counter at zero: the run-out and the reload both want the counter, and only the reload may act. The bench provokes this with a zero length, so that every enabled tick would run out. It places a keyed restart, then a keyed length write, exactly on such ticks, and requires both the reset pin and the status register to stay quiet. A keyed mode write landing on a run-out tick is likewise judged by status bit 31 surviving the clear. Beyond the directed cases, a long mixed stream of keyed and unkeyed accesses is compared against a behavioural model on every clock.

// File: rtl/kwdt_pkg.sv
package kwdt_pkg;

    // Register offsets (byte addresses)
    localparam logic [7:0] OFS_MODE  = 8'h00;
    localparam logic [7:0] OFS_LEN   = 8'h04;
    localparam logic [7:0] OFS_KICK  = 8'h08;
    localparam logic [7:0] OFS_STAT  = 8'h0C;
    localparam logic [7:0] OFS_CNT   = 8'h10;
    localparam logic [7:0] OFS_SWRST = 8'h14;

    // Write keys
    localparam logic [7:0]  MODE_KEY  = 8'h22;
    localparam logic [4:0]  LEN_KEY   = 5'h08;
    localparam logic [31:0] KICK_KEY  = 32'h0000_1971;
    localparam logic [31:0] SWRST_KEY = 32'h0000_1209;

    // Mode bit positions
    localparam int B_EN   = 0;
    localparam int B_POL  = 1;
    localparam int B_EXT  = 2;
    localparam int B_IRQ  = 3;
    localparam int B_DUAL = 6;

    // Length field base bit
    localparam int LEN_LSB = 5;

    // Status bit positions
    localparam int B_STS_TO = 31;
    localparam int B_STS_SW = 30;

    // Accepted (key-checked) write strobes
    typedef struct packed {
        logic mode_wr;
        logic len_wr;
        logic kick;
        logic swrst;
    } kwdt_wr_t;

    // Control and status state held in the top
    typedef struct packed {
        logic en;
        logic pol;
        logic ext;
        logic irq_en;
        logic dual;
        logic pend;
        logic sts_to;
        logic sts_sw;
    } kwdt_ctl_t;

endpackage

// File: rtl/kwdt_decode.sv
module kwdt_decode
    import kwdt_pkg::*;
#(
    parameter int ADDR_W = 8
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic              we,
    input  logic [31:0]       wdata,
    output kwdt_wr_t          wr
);

    always_comb begin
        wr = '0;
        if (we) begin
            wr.mode_wr = (addr == ADDR_W'(OFS_MODE))  && (wdata[31:24] == MODE_KEY);
            wr.len_wr  = (addr == ADDR_W'(OFS_LEN))   && (wdata[LEN_LSB-1:0] == LEN_KEY);
            wr.kick    = (addr == ADDR_W'(OFS_KICK))  && (wdata == KICK_KEY);
            wr.swrst   = (addr == ADDR_W'(OFS_SWRST)) && (wdata == SWRST_KEY);
        end
    end

endmodule

// File: rtl/kwdt_counter.sv
module kwdt_counter #(
    parameter int TMO_W      = 11,
    parameter int UNIT_SHIFT = 9
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        tick,
    input  logic                        en,
    input  logic                        load,
    input  logic [TMO_W-1:0]            load_val,
    input  logic                        kick,
    output logic [TMO_W-1:0]            len,
    output logic [TMO_W+UNIT_SHIFT-1:0] cnt,
    output logic                        expire
);

    localparam int CNT_W = TMO_W + UNIT_SHIFT;

    typedef struct packed {
        logic [TMO_W-1:0] len;
        logic [CNT_W-1:0] cnt;
    } cnt_st_t;

    cnt_st_t st_d, st_q;

    function automatic logic [CNT_W-1:0] span(input logic [TMO_W-1:0] units);
        return {units, {UNIT_SHIFT{1'b0}}};
    endfunction

    always_comb begin
        st_d   = st_q;
        expire = 1'b0;
        if (en && tick) begin
            if (st_q.cnt == '0) begin
                // reload on run-out; a same-cycle software reload suppresses it
                expire   = !(load || kick);
                st_d.cnt = span(st_q.len);
            end else begin
                st_d.cnt = st_q.cnt - CNT_W'(1);
            end
        end
        if (load) begin
            st_d.len = load_val;
            st_d.cnt = span(load_val);
        end else if (kick) begin
            st_d.cnt = span(st_q.len);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign len = st_q.len;
    assign cnt = st_q.cnt;

endmodule

// File: rtl/kwdt_pulse.sv
module kwdt_pulse #(
    parameter int PULSE_LEN = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic fire,
    input  logic pol,
    output logic pin
);

    localparam int PW = $clog2(PULSE_LEN + 1);

    logic [PW-1:0] left_d, left_q;
    logic          active;

    always_comb begin
        left_d = left_q;
        if (fire) begin
            left_d = PW'(PULSE_LEN);
        end else if (left_q != '0) begin
            left_d = left_q - PW'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            left_q <= '0;
        end else begin
            left_q <= left_d;
        end
    end

    assign active = (left_q != '0);
    assign pin    = pol ? active : !active;

endmodule

// File: rtl/keyed_wdt.sv
module keyed_wdt
    import kwdt_pkg::*;
#(
    parameter int ADDR_W     = 8,
    parameter int TMO_W      = 11,
    parameter int UNIT_SHIFT = 9,
    parameter int PULSE_LEN  = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_we,
    input  logic [31:0]       bus_wdata,
    output logic [31:0]       bus_rdata,
    output logic              wdt_rst_out,
    output logic              wdt_irq
);

    localparam int CNT_W = TMO_W + UNIT_SHIFT;

    kwdt_wr_t         wr;
    kwdt_ctl_t        ctl_d, ctl_q;
    logic [TMO_W-1:0] len_w;
    logic [CNT_W-1:0] cnt_w;
    logic             expire_w;
    logic             rst_evt;
    logic             irq_evt;
    logic             fire;

    // observation points for the bound checker
    logic mode_en_w;
    logic mode_pol_w;
    logic sts_sw_w;

    kwdt_decode #(
        .ADDR_W (ADDR_W)
    ) u_decode (
        .addr  (bus_addr),
        .we    (bus_we),
        .wdata (bus_wdata),
        .wr    (wr)
    );

    kwdt_counter #(
        .TMO_W      (TMO_W),
        .UNIT_SHIFT (UNIT_SHIFT)
    ) u_counter (
        .clk      (clk),
        .rst_n    (rst_n),
        .tick     (tick),
        .en       (ctl_q.en),
        .load     (wr.len_wr),
        .load_val (bus_wdata[LEN_LSB +: TMO_W]),
        .kick     (wr.kick),
        .len      (len_w),
        .cnt      (cnt_w),
        .expire   (expire_w)
    );

    kwdt_pulse #(
        .PULSE_LEN (PULSE_LEN)
    ) u_pulse (
        .clk   (clk),
        .rst_n (rst_n),
        .fire  (fire),
        .pol   (ctl_q.pol),
        .pin   (wdt_rst_out)
    );

    always_comb begin
        ctl_d   = ctl_q;
        rst_evt = expire_w && (!ctl_q.dual || ctl_q.pend);
        irq_evt = expire_w && ctl_q.dual && !ctl_q.pend;
        fire    = (rst_evt && ctl_q.ext) || wr.swrst;

        if (wr.mode_wr) begin
            ctl_d.en     = bus_wdata[B_EN];
            ctl_d.pol    = bus_wdata[B_POL];
            ctl_d.ext    = bus_wdata[B_EXT];
            ctl_d.irq_en = bus_wdata[B_IRQ];
            ctl_d.dual   = bus_wdata[B_DUAL];
            ctl_d.sts_to = 1'b0;
            ctl_d.sts_sw = 1'b0;
        end

        if (wr.kick || rst_evt) begin
            ctl_d.pend = 1'b0;
        end else if (irq_evt) begin
            ctl_d.pend = 1'b1;
        end

        // events win over a same-cycle clear
        if (rst_evt) begin
            ctl_d.sts_to = 1'b1;
        end
        if (wr.swrst) begin
            ctl_d.sts_sw = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctl_q <= '0;
        end else begin
            ctl_q <= ctl_d;
        end
    end

    always_comb begin
        bus_rdata = '0;
        case (bus_addr)
            ADDR_W'(OFS_MODE): begin
                bus_rdata[B_EN]   = ctl_q.en;
                bus_rdata[B_POL]  = ctl_q.pol;
                bus_rdata[B_EXT]  = ctl_q.ext;
                bus_rdata[B_IRQ]  = ctl_q.irq_en;
                bus_rdata[B_DUAL] = ctl_q.dual;
            end
            ADDR_W'(OFS_LEN): begin
                bus_rdata = 32'(len_w) << LEN_LSB;
            end
            ADDR_W'(OFS_STAT): begin
                bus_rdata[B_STS_TO] = ctl_q.sts_to;
                bus_rdata[B_STS_SW] = ctl_q.sts_sw;
            end
            ADDR_W'(OFS_CNT): begin
                bus_rdata = 32'(cnt_w);
            end
            default: bus_rdata = '0;
        endcase
    end

    assign wdt_irq    = ctl_q.pend && ctl_q.irq_en;
    assign mode_en_w  = ctl_q.en;
    assign mode_pol_w = ctl_q.pol;
    assign sts_sw_w   = ctl_q.sts_sw;

endmodule

// File: rtl/kwdt_checker.sv
module kwdt_checker
    import kwdt_pkg::*;
#(
    parameter int ADDR_W     = 8,
    parameter int TMO_W      = 11,
    parameter int UNIT_SHIFT = 9
) (
    input logic                        clk,
    input logic                        rst_n,
    input logic                        tick,
    input logic [ADDR_W-1:0]           bus_addr,
    input logic                        bus_we,
    input logic [31:0]                 bus_wdata,
    input logic                        wdt_rst_out,
    input logic [TMO_W-1:0]            len,
    input logic [TMO_W+UNIT_SHIFT-1:0] cnt,
    input logic                        en,
    input logic                        pol,
    input logic                        sts_sw
);

    localparam int CNT_W = TMO_W + UNIT_SHIFT;

    logic hit_len, hit_kick, hit_mode, hit_swrst, mapped;

    assign hit_len   = (bus_addr == ADDR_W'(OFS_LEN));
    assign hit_kick  = (bus_addr == ADDR_W'(OFS_KICK));
    assign hit_mode  = (bus_addr == ADDR_W'(OFS_MODE));
    assign hit_swrst = (bus_addr == ADDR_W'(OFS_SWRST));
    assign mapped    = hit_len || hit_kick || hit_mode || hit_swrst
                    || (bus_addr == ADDR_W'(OFS_STAT))
                    || (bus_addr == ADDR_W'(OFS_CNT));

    // R5: disabled counter holds unless reloaded
    assert_frozen_count_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (!en && !(bus_we && (hit_len || hit_kick))) |=> $stable(cnt));

    // R5: enabled counter steps down by one per tick
    assert_step_down_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (en && tick && (cnt != '0) && !bus_we) |=> (cnt == $past(cnt) - CNT_W'(1)));

    // R4: keyed restart reloads to the programmed span
    assert_kick_reload_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_we && hit_kick && (bus_wdata == KICK_KEY)) |=> (cnt == {len, {UNIT_SHIFT{1'b0}}}));

    // R9: keyed software reset drives the pin active and records it
    assert_swrst_fires_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_we && hit_swrst && (bus_wdata == SWRST_KEY)) |=> (sts_sw && (wdt_rst_out == pol)));

    // R2: unkeyed mode writes leave the mode alone
    assert_badkey_mode_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_we && hit_mode && (bus_wdata[31:24] != MODE_KEY)) |=> ($stable(en) && $stable(pol)));

    // R11: writes off the map touch nothing
    assert_unmapped_write_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_we && !mapped) |=> ($stable(en) && $stable(pol) && $stable(sts_sw) && $stable(len)));

endmodule

bind keyed_wdt kwdt_checker #(
    .ADDR_W     (ADDR_W),
    .TMO_W      (TMO_W),
    .UNIT_SHIFT (UNIT_SHIFT)
) chk_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .tick        (tick),
    .bus_addr    (bus_addr),
    .bus_we      (bus_we),
    .bus_wdata   (bus_wdata),
    .wdt_rst_out (wdt_rst_out),
    .len         (len_w),
    .cnt         (cnt_w),
    .en          (mode_en_w),
    .pol         (mode_pol_w),
    .sts_sw      (sts_sw_w)
);

// File: tb/keyed_wdt_tb_top.sv
module keyed_wdt_tb_top;

    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        tick = 1'b0;
    logic [7:0]  bus_addr = 8'h00;
    logic        bus_we = 1'b0;
    logic [31:0] bus_wdata = 32'h0;
    logic [31:0] bus_rdata;
    logic        wdt_rst_out;
    logic        wdt_irq;

    always #(CLK_PERIOD/2) clk = ~clk;

    keyed_wdt dut_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .tick        (tick),
        .bus_addr    (bus_addr),
        .bus_we      (bus_we),
        .bus_wdata   (bus_wdata),
        .bus_rdata   (bus_rdata),
        .wdt_rst_out (wdt_rst_out),
        .wdt_irq     (wdt_irq)
    );

    int    n_cmp = 0;
    int    n_bad = 0;
    string cur_req = "R1";
    bit    done = 0;

    // ---------------- behavioural reference ----------------
    bit          m_en, m_pol, m_ext, m_irqen, m_dual, m_pend, m_to, m_sw;
    int unsigned m_len, m_cnt, m_pls, ncnt;
    bit          lw, kw, mw, sw, exp_now, rev, iev;

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_en = 0; m_pol = 0; m_ext = 0; m_irqen = 0; m_dual = 0;
            m_pend = 0; m_to = 0; m_sw = 0;
            m_len = 0; m_cnt = 0; m_pls = 0;
        end else begin
            lw = bus_we && bus_addr == 8'h04 && bus_wdata[4:0] == 5'h08;
            kw = bus_we && bus_addr == 8'h08 && bus_wdata == 32'h1971;
            mw = bus_we && bus_addr == 8'h00 && bus_wdata[31:24] == 8'h22;
            sw = bus_we && bus_addr == 8'h14 && bus_wdata == 32'h1209;
            exp_now = m_en && tick && (m_cnt == 0) && !lw && !kw;
            rev = exp_now && (!m_dual || m_pend);
            iev = exp_now && m_dual && !m_pend;
            ncnt = m_cnt;
            if (m_en && tick) ncnt = (m_cnt == 0) ? m_len * 512 : m_cnt - 1;
            if (lw) begin
                m_len = (bus_wdata >> 5) & 32'h7FF;
                ncnt  = m_len * 512;
            end else if (kw) begin
                ncnt = m_len * 512;
            end
            m_cnt = ncnt;
            if (kw || rev) m_pend = 0;
            else if (iev) m_pend = 1;
            if ((rev && m_ext) || sw) m_pls = 16;
            else if (m_pls > 0) m_pls = m_pls - 1;
            if (mw) begin
                m_en = bus_wdata[0]; m_pol = bus_wdata[1]; m_ext = bus_wdata[2];
                m_irqen = bus_wdata[3]; m_dual = bus_wdata[6];
                m_to = 0; m_sw = 0;
            end
            if (rev) m_to = 1;
            if (sw) m_sw = 1;
        end
    end

    function automatic logic [31:0] mread(input logic [7:0] a);
        case (a)
            8'h00: return {25'b0, m_dual, 2'b0, m_irqen, m_ext, m_pol, m_en};
            8'h04: return m_len << 5;
            8'h0C: return {m_to, m_sw, 30'b0};
            8'h10: return m_cnt;
            default: return 32'h0;
        endcase
    endfunction

    task automatic check_val(input logic [31:0] act, input logic [31:0] exp, input string what);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %h expected %h at %0t", cur_req, what, act, exp, $time);
        end
    endtask

    task automatic step(input logic t, input logic w, input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        check_val({31'b0, wdt_rst_out}, {31'b0, (m_pol ? (m_pls > 0) : !(m_pls > 0))}, "rst_out");
        check_val({31'b0, wdt_irq}, {31'b0, m_pend && m_irqen}, "irq");
        tick = t; bus_we = w; bus_addr = a; bus_wdata = d;
        #1;
        check_val(bus_rdata, mread(a), "rdata");
    endtask

    task automatic idle(input int n, input logic t, input logic [7:0] a);
        for (int i = 0; i < n; i++) step(t, 1'b0, a, 32'h0);
    endtask

    task automatic read_all();
        step(0, 0, 8'h00, 0); step(0, 0, 8'h04, 0); step(0, 0, 8'h08, 0);
        step(0, 0, 8'h0C, 0); step(0, 0, 8'h10, 0); step(0, 0, 8'h14, 0);
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;

        cur_req = "R1";  read_all();

        cur_req = "R11";
        step(0, 1, 8'h18, 32'h22000047); step(0, 1, 8'hFC, 32'h1209);
        step(0, 1, 8'h0C, 32'hFFFFFFFF); step(0, 1, 8'h10, 32'h1971);
        step(0, 0, 8'h18, 0); step(0, 0, 8'h40, 0); read_all();

        cur_req = "R3";
        step(0, 1, 8'h04, 32'h0000_0029); step(0, 0, 8'h04, 0);
        step(0, 1, 8'h04, 32'h0000_0028); step(0, 0, 8'h04, 0); step(0, 0, 8'h10, 0);

        cur_req = "R2";
        step(0, 1, 8'h00, 32'h2100_0005); step(0, 0, 8'h00, 0);
        step(0, 1, 8'h00, 32'hFF22_FF4F); step(0, 0, 8'h00, 0);
        step(0, 1, 8'h00, 32'h22FF_FF05); step(0, 0, 8'h00, 0);

        cur_req = "R5";  idle(40, 1, 8'h10); idle(10, 0, 8'h10);
        cur_req = "R6";  idle(520, 1, 8'h10); idle(20, 0, 8'h0C);
        cur_req = "R5";
        step(0, 1, 8'h00, 32'h2200_0004); idle(30, 1, 8'h10);

        cur_req = "R7";
        step(0, 1, 8'h04, 32'h0000_0008);
        step(0, 1, 8'h00, 32'h2200_0007);
        step(1, 0, 8'h0C, 0); idle(20, 0, 8'h0C);
        step(0, 1, 8'h00, 32'h2200_0004); idle(3, 0, 8'h00);

        cur_req = "R12";
        step(0, 1, 8'h00, 32'h2200_0005);
        step(1, 1, 8'h08, 32'h0000_1971); step(0, 0, 8'h0C, 0);
        step(1, 1, 8'h04, 32'h0000_0008); idle(4, 0, 8'h0C);
        step(1, 0, 8'h0C, 0); idle(20, 0, 8'h0C);

        cur_req = "R8";
        step(0, 1, 8'h00, 32'h2200_004D);
        step(1, 0, 8'h10, 0); idle(5, 0, 8'h0C);
        step(1, 0, 8'h10, 0); idle(20, 0, 8'h0C);
        step(1, 0, 8'h10, 0); idle(3, 0, 8'h0C);
        step(0, 1, 8'h08, 32'h0000_1971); idle(3, 0, 8'h0C);

        cur_req = "R4";
        step(0, 1, 8'h00, 32'h2200_0000);
        step(0, 1, 8'h04, 32'h0000_0048);
        step(0, 1, 8'h00, 32'h2200_0001); idle(100, 1, 8'h10);
        step(0, 1, 8'h08, 32'h0000_1970); step(0, 1, 8'h08, 32'h0001_1971);
        step(0, 0, 8'h10, 0);
        step(0, 1, 8'h08, 32'h0000_1971); step(0, 0, 8'h10, 0); step(0, 0, 8'h08, 0);

        cur_req = "R9";
        step(0, 1, 8'h14, 32'h0000_1208); idle(3, 0, 8'h0C);
        step(1, 1, 8'h14, 32'h0000_1209); idle(20, 0, 8'h0C); step(0, 0, 8'h14, 0);

        cur_req = "R10";
        step(0, 1, 8'h00, 32'h2200_0000); step(0, 0, 8'h0C, 0);
        step(0, 1, 8'h04, 32'h0000_0008);
        step(0, 1, 8'h00, 32'h2200_0005);
        step(1, 1, 8'h00, 32'h2200_0005); step(0, 0, 8'h0C, 0);
        step(0, 1, 8'h14, 32'h0000_1209);
        step(0, 1, 8'h00, 32'h2200_0001); idle(20, 0, 8'h0C);

        cur_req = "R6";
        for (int i = 0; i < 4000; i++) begin
            int unsigned r;
            logic [7:0]  a;
            logic [31:0] d;
            r = $urandom;
            a = 8'(4 * (r % 7));
            case (a)
                8'h00: d = ((r >> 8) % 8 != 0) ? {8'h22, 17'b0, 7'((r >> 12) | 32'h1)} : r;
                8'h04: d = ((r >> 8) % 6 != 0) ? (((r >> 12) % 3) << 5) | 32'h8 : r;
                8'h08: d = ((r >> 8) % 2 == 0) ? 32'h1971 : 32'h1970;
                8'h14: d = ((r >> 8) % 10 == 0) ? 32'h1209 : 32'h0;
                default: d = r;
            endcase
            step(((r >> 20) % 2) == 1, ((r >> 24) % 16) == 0, a, d);
        end
        idle(20, 0, 8'h0C);

        done = 1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule